// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator

This block drives three half-bridge legs. Each leg has a high-side and a low-side gate output, and the two are always complementary. A phase accumulator sets the rate of the internal PWM clock. The period counter advances on that clock and runs through 2048 counts per period. Read as a triangle, the counter gives a center-aligned reference for each leg. Each leg compares its duty value against that reference. Every switch turn-on is held back by a programmed dead time, so the two switches of a leg never conduct at once.

Software works through a four-entry write/read register port. The entries hold the packed duty word, the enable request and fault status, the setup word (dead time, fault polarity and sample position) and the rate. A fault input with selectable polarity overrides the enable request. The fault clears the enable request, and the request stays cleared until software writes it again. A single-cycle sample strobe marks a programmable point in every PWM period, so converters can sample at a quiet moment.

Top module: `tpwm_top`

## Requirements
- R1: After reset every gate output, `amp_en` and `smp_strobe` are 0, and all four registers read 0.
- R2: The register addresses are 0 for duty, 1 for control, 2 for setup and 3 for rate. Duty reads back bits 29:0, setup reads back bits 25:16, 15 and 8:0, and rate reads back bits 15:0. All other bits read 0.
- R3: A PWM clock tick occurs whenever the 16-bit accumulator, advanced by the rate every clock, carries out. One period is 2048 ticks, so a rate of 32768 gives a period of 4096 clocks and a rate of 16384 gives 8192 clocks. A rate of 0 stops the ticks, and no strobe appears.
- R4: Phase p takes its duty D from duty-register bits 10p+9:10p. With zero dead time the high side is active for 2·D ticks per period less one clock, and never when D is 0.
- R5: With zero dead time the low side is active for 2·(1024−D) ticks per period less one clock. When D is 0 the low side is active for the whole period.
- R6: The high and low outputs of a leg are never both 1. Before a switch turns on, the other switch of that leg has been off for at least one clock.
- R7: Setup bits 8:0 hold the dead time T. In every leg the gap between one switch turning off and the other turning on spans at least 2·T ticks and at most one extra tick.
- R8: Writing 1 to control bit 0 requests enable, and writing 0 removes the request. `amp_en` is 1 only while the request is set and no fault is present. While `amp_en` is 0, all six gate outputs are 0 from the next clock on.
- R9: Setup bit 15 selects the fault level. When the bit is 0, a low `fault_in` is a fault. When it is 1, a high `fault_in` is a fault. Control bit 1 reads the registered fault state one clock after the input changes.
- R10: A fault clears the enable request. The request stays 0 after the fault goes away, and a write of 1 while the fault is present is ignored.
- R11: Setup bits 25:16 hold the sample position S. `smp_strobe` pulses for one clock once per period, 2·S ticks after the period start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| fault_in | input | 1 | External fault input |
| gate_hi | output | 3 | High-side gate drives, phases A to C |
| gate_lo | output | 3 | Low-side gate drives, phases A to C |
| amp_en | output | 1 | Amplifier enable |
| smp_strobe | output | 1 | Per-period sample strobe |

## Verification
The duty patterns are directed extremes (0, 1, 512, 1022, 1023) followed by random triples, with a different value in each phase. Giving each phase its own value separates one duty field from another. Counting high and low clocks over exact periods catches any off-by-one error in the compare. The strobe is timed against a fixed baseline while the sample position changes, and this separates the strobe position from the period length. A separate test checks that rate 0 halts the block. Fault tests use both polarities and writes made during a fault, which separates the latched enable clear from plain gating by the fault.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;
   typedef enum logic [1:0] {
      A_DUTY  = 2'd0,
      A_CTRL  = 2'd1,
      A_SETUP = 2'd2,
      A_RATE  = 2'd3
   } tpwm_addr_e;
endpackage

// File: rtl/tpwm_rate.sv
module tpwm_rate #(
   parameter int RATE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RATE_W-1:0] rate,
   output logic              tick
);
   logic [RATE_W-1:0] acc;
   logic [RATE_W:0]   sum;

   assign sum = {1'b0, acc} + {1'b0, rate};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc  <= '0;
         tick <= 1'b0;
      end else begin
         acc  <= sum[RATE_W-1:0];
         tick <= sum[RATE_W];
      end
   end
endmodule

// File: rtl/tpwm_counter.sv
module tpwm_counter #(
   parameter int CNT_W  = 11,
   parameter int SAMP_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [SAMP_W-1:0] samp,
   output logic [CNT_W-2:0]  tri_val,
   output logic              strobe
);
   localparam int SHIFT = CNT_W - SAMP_W;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] samp_pos;

   generate
      if (SHIFT < 1) begin : g_bad_samp
         $error("tpwm_counter: SAMP_W must be below CNT_W");
      end
   endgenerate

   assign samp_pos = {samp, {SHIFT{1'b0}}};
   assign tri_val  = cnt[CNT_W-1] ? ~cnt[CNT_W-2:0] : cnt[CNT_W-2:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         strobe <= 1'b0;
      end else begin
         strobe <= tick && (cnt == samp_pos);
         if (tick) cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/tpwm_leg.sv
module tpwm_leg #(
   parameter int DUTY_W = 10,
   parameter int DEAD_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              tick,
   input  logic [DUTY_W-1:0] tri_val,
   input  logic [DUTY_W-1:0] duty,
   input  logic [DEAD_W-1:0] dead,
   output logic              hi,
   output logic              lo
);
   logic            req;
   logic            cur;
   logic [DEAD_W:0] dt;

   assign req = tri_val < duty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi  <= 1'b0;
         lo  <= 1'b0;
         cur <= 1'b0;
         dt  <= '0;
      end else if (!run) begin
         hi  <= 1'b0;
         lo  <= 1'b0;
         cur <= req;
         dt  <= {dead, 1'b0};
      end else if (req != cur) begin
         hi  <= 1'b0;
         lo  <= 1'b0;
         cur <= req;
         dt  <= {dead, 1'b0};
      end else if (dt != '0) begin
         if (tick) dt <= dt - 1'b1;
      end else begin
         hi <= cur;
         lo <= ~cur;
      end
   end
endmodule

// File: rtl/tpwm_top.sv
module tpwm_top #(
   parameter int PHASES   = 3,
   parameter int DUTY_W   = 10,
   parameter int CNT_W    = 11,
   parameter int RATE_W   = 16,
   parameter int DEAD_W   = 9,
   parameter int SAMP_W   = 10,
   parameter int POL_BIT  = 15,
   parameter int SAMP_LSB = 16,
   parameter int DATA_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [1:0]        rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              fault_in,
   output logic [PHASES-1:0] gate_hi,
   output logic [PHASES-1:0] gate_lo,
   output logic              amp_en,
   output logic              smp_strobe
);
   import tpwm_pkg::*;

   localparam int DUTY_BITS = PHASES * DUTY_W;

   generate
      if (DUTY_W != CNT_W - 1) begin : g_bad_duty
         $error("tpwm_top: DUTY_W must equal CNT_W-1");
      end
      if (DUTY_BITS > DATA_W || RATE_W > DATA_W) begin : g_bad_width
         $error("tpwm_top: register field wider than data word");
      end
      if (DEAD_W > POL_BIT || POL_BIT >= SAMP_LSB || SAMP_LSB + SAMP_W > DATA_W) begin : g_bad_setup
         $error("tpwm_top: setup fields overlap");
      end
   endgenerate

   logic [DUTY_BITS-1:0] duty_q;
   logic [DEAD_W-1:0]    dead_q;
   logic                 pol_q;
   logic [SAMP_W-1:0]    samp_q;
   logic [RATE_W-1:0]    rate_q;
   logic                 en_q;
   logic                 fault_q;
   logic                 tick_w;
   logic [DUTY_W-1:0]    tri_w;
   logic                 wr_unused;
   tpwm_addr_e           wa;

   assign wr_unused = ^wr_data;
   assign wa        = tpwm_addr_e'(wr_addr);
   assign amp_en    = en_q & ~fault_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         duty_q  <= '0;
         dead_q  <= '0;
         pol_q   <= 1'b0;
         samp_q  <= '0;
         rate_q  <= '0;
         en_q    <= 1'b0;
         fault_q <= 1'b0;
      end else begin
         fault_q <= pol_q ? fault_in : ~fault_in;
         if (wr_en && wa == A_CTRL) en_q <= wr_data[0] & ~fault_q;
         else if (fault_q)          en_q <= 1'b0;
         if (wr_en && wa == A_DUTY) duty_q <= wr_data[DUTY_BITS-1:0];
         if (wr_en && wa == A_RATE) rate_q <= wr_data[RATE_W-1:0];
         if (wr_en && wa == A_SETUP) begin
            dead_q <= wr_data[DEAD_W-1:0];
            pol_q  <= wr_data[POL_BIT];
            samp_q <= wr_data[SAMP_LSB +: SAMP_W];
         end
      end
   end

   always_comb begin
      rd_data = '0;
      case (tpwm_addr_e'(rd_addr))
         A_DUTY:  rd_data[DUTY_BITS-1:0] = duty_q;
         A_CTRL:  rd_data[1:0] = {fault_q, en_q};
         A_SETUP: begin
            rd_data[DEAD_W-1:0]          = dead_q;
            rd_data[POL_BIT]             = pol_q;
            rd_data[SAMP_LSB +: SAMP_W]  = samp_q;
         end
         default: rd_data[RATE_W-1:0] = rate_q;
      endcase
   end

   tpwm_rate #(.RATE_W(RATE_W)) u_rate (
      .clk(clk), .rst_n(rst_n), .rate(rate_q), .tick(tick_w)
   );

   tpwm_counter #(.CNT_W(CNT_W), .SAMP_W(SAMP_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick_w), .samp(samp_q),
      .tri_val(tri_w), .strobe(smp_strobe)
   );

   generate
      for (genvar p = 0; p < PHASES; p++) begin : g_leg
         tpwm_leg #(.DUTY_W(DUTY_W), .DEAD_W(DEAD_W)) u_leg (
            .clk(clk), .rst_n(rst_n), .run(amp_en), .tick(tick_w),
            .tri_val(tri_w), .duty(duty_q[p*DUTY_W +: DUTY_W]),
            .dead(dead_q), .hi(gate_hi[p]), .lo(gate_lo[p])
         );
      end
   endgenerate
endmodule

// File: rtl/tpwm_chk.sv
module tpwm_chk #(
   parameter int PHASES = 3,
   parameter int RATE_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [PHASES-1:0] hi,
   input logic [PHASES-1:0] lo,
   input logic              amp_en,
   input logic              strobe,
   input logic              en_bit,
   input logic              flt,
   input logic              tick,
   input logic [RATE_W-1:0] rate
);
   assert_no_shoot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hi & lo) == '0);

   generate
      for (genvar p = 0; p < PHASES; p++) begin : g_p
         assert_hi_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(hi[p]) |-> $past(!lo[p]));
         assert_lo_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(lo[p]) |-> $past(!hi[p]));
      end
   endgenerate

   assert_idle_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !amp_en |=> ((hi | lo) == '0));

   assert_fault_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flt |=> !en_bit);

   assert_strobe_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> !strobe);

   assert_halt_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rate == '0) |=> !tick);
endmodule

bind tpwm_top tpwm_chk #(.PHASES(PHASES), .RATE_W(RATE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .hi(gate_hi), .lo(gate_lo), .amp_en(amp_en),
   .strobe(smp_strobe), .en_bit(en_q), .flt(fault_q), .tick(tick_w), .rate(rate_q)
);

// File: tb/sim_tpwm_top.sv
`timescale 1ns/1ps
module sim_tpwm_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [1:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        fault_in = 1'b1;
   logic [2:0]  gate_hi, gate_lo;
   logic        amp_en, smp_strobe;

   int      checks = 0;
   int      fails = 0;
   longint  cyc = 0;
   bit      done = 0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc++;

   tpwm_top u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .fault_in(fault_in),
      .gate_hi(gate_hi), .gate_lo(gate_lo), .amp_en(amp_en), .smp_strobe(smp_strobe)
   );

   function automatic int exp_hi(int d);
      return (d == 0) ? 0 : 4*d - 1;
   endfunction
   function automatic int exp_lo(int d);
      return (d == 0) ? 4096 : 4*(1024-d) - 1;
   endfunction
   function automatic logic [31:0] setup_word(int dead, int pol, int samp);
      return (32'(samp) << 16) | (32'(pol) << 15) | 32'(dead);
   endfunction

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(logic [1:0] a, output logic [31:0] d);
      @(negedge clk); rd_addr = a; #0.5; d = rd_data;
   endtask

   task automatic clocks(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_strobe(output longint t);
      do @(negedge clk); while (!smp_strobe);
      t = cyc;
   endtask

   task automatic measure(output int hc[3], output int lc[3], output int ov, output int sc);
      ov = 0; sc = 0;
      for (int p = 0; p < 3; p++) begin hc[p] = 0; lc[p] = 0; end
      repeat (4096) begin
         @(negedge clk);
         for (int p = 0; p < 3; p++) begin
            hc[p] += int'(gate_hi[p]);
            lc[p] += int'(gate_lo[p]);
         end
         if ((gate_hi & gate_lo) != 3'b0) ov++;
         if (smp_strobe) sc++;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog run did not finish actual=%0d expected=%0d", cyc, 190000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      int hc[3], lc[3], ov, sc;
      int duties[8][3];
      longint t0, t1, ta, tb;
      int s_list[3];
      void'($urandom(32'd20240611));

      clocks(3);
      // R1 reset state
      chk(gate_hi == 0 && gate_lo == 0, "R1", "gates after reset", {gate_hi, gate_lo}, 0);
      chk(amp_en == 0 && smp_strobe == 0, "R1", "amp_en/strobe after reset", {amp_en, smp_strobe}, 0);
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), v);
         chk(v == 0, "R1", "register reset value", v, 0);
      end
      rst_n = 1'b1;
      clocks(2);

      // R2 register map readback
      wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, v); chk(v == 32'h3FFF_FFFF, "R2", "duty readback", v, 32'h3FFF_FFFF);
      wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, v); chk(v == 32'h03FF_81FF, "R2", "setup readback", v, 32'h03FF_81FF);
      wr(2'd3, 32'hFFFF_FFFF); rd(2'd3, v); chk(v == 32'h0000_FFFF, "R2", "rate readback", v, 32'hFFFF);

      wr(2'd2, setup_word(0, 0, 0));
      wr(2'd3, 32'd32768);
      wr(2'd0, 32'h2008_0200);
      wr(2'd1, 32'd1);
      rd(2'd1, v); chk(v == 32'd1, "R8", "enable readback", v, 1);
      chk(amp_en == 1'b1, "R8", "amp_en after enable", amp_en, 1);

      // R4 R5 R6 duty patterns: directed then random
      duties[0] = '{512, 0, 1023};
      duties[1] = '{1, 1022, 300};
      duties[2] = '{0, 512, 700};
      for (int k = 3; k < 8; k++)
         for (int p = 0; p < 3; p++) duties[k][p] = int'($urandom_range(0, 1023));
      for (int k = 0; k < 8; k++) begin
         wr(2'd0, (32'(duties[k][2]) << 20) | (32'(duties[k][1]) << 10) | 32'(duties[k][0]));
         clocks(4200);
         measure(hc, lc, ov, sc);
         for (int p = 0; p < 3; p++) begin
            chk(hc[p] == exp_hi(duties[k][p]), "R4", $sformatf("high clocks phase %0d", p), hc[p], exp_hi(duties[k][p]));
            chk(lc[p] == exp_lo(duties[k][p]), "R5", $sformatf("low clocks phase %0d", p), lc[p], exp_lo(duties[k][p]));
         end
         chk(ov == 0, "R6", "overlap clocks", ov, 0);
         chk(sc == 1, "R11", "strobes per period", sc, 1);
      end

      // R3 period from rate
      wait_strobe(ta); wait_strobe(tb);
      chk(tb - ta == 4096, "R3", "period at rate 32768", tb - ta, 4096);
      wr(2'd3, 32'd16384);
      wait_strobe(ta); wait_strobe(ta); wait_strobe(tb);
      chk(tb - ta == 8192, "R3", "period at rate 16384", tb - ta, 8192);
      wr(2'd3, 32'd32768);
      wait_strobe(ta);

      // R11 sample position shift
      wait_strobe(t0);
      s_list = '{256, 1023, 1};
      for (int i = 0; i < 3; i++) begin
         wr(2'd2, setup_word(0, 0, s_list[i]));
         wait_strobe(t1);
         chk(((t1 - t0) % 4096) == ((4*s_list[i]) % 4096), "R11", $sformatf("strobe offset s=%0d", s_list[i]),
             (t1 - t0) % 4096, (4*s_list[i]) % 4096);
      end

      // R7 dead time
      begin
         longint lo_fall[3], hi_fall[3];
         logic [2:0] ph, pl;
         longint gmin, gmax, g;
         gmin = 1000000; gmax = 0;
         wr(2'd2, setup_word(5, 0, 0));
         wr(2'd0, 32'h2008_0200);
         clocks(4200);
         for (int p = 0; p < 3; p++) begin lo_fall[p] = -1; hi_fall[p] = -1; end
         ph = gate_hi; pl = gate_lo;
         repeat (8192) begin
            @(negedge clk);
            for (int p = 0; p < 3; p++) begin
               if (pl[p] && !gate_lo[p]) lo_fall[p] = cyc;
               if (ph[p] && !gate_hi[p]) hi_fall[p] = cyc;
               if (!ph[p] && gate_hi[p] && lo_fall[p] >= 0) begin
                  g = cyc - lo_fall[p]; if (g < gmin) gmin = g; if (g > gmax) gmax = g;
               end
               if (!pl[p] && gate_lo[p] && hi_fall[p] >= 0) begin
                  g = cyc - hi_fall[p]; if (g < gmin) gmin = g; if (g > gmax) gmax = g;
               end
            end
            ph = gate_hi; pl = gate_lo;
         end
         chk(gmin >= 20, "R7", "minimum dead gap clocks", gmin, 20);
         chk(gmax <= 22, "R7", "maximum dead gap clocks", gmax, 22);
      end

      // R8 disable
      wr(2'd1, 32'd0);
      clocks(1);
      chk(amp_en == 0, "R8", "amp_en after disable", amp_en, 0);
      ov = 0;
      repeat (200) begin @(negedge clk); if ((gate_hi | gate_lo) != 0) ov++; end
      chk(ov == 0, "R8", "active gate clocks while disabled", ov, 0);
      wr(2'd1, 32'd1);
      chk(amp_en == 1, "R8", "amp_en after re-enable", amp_en, 1);

      // R9 R10 fault, active low
      fault_in = 1'b0;
      clocks(3);
      chk(amp_en == 0, "R9", "amp_en during low fault", amp_en, 0);
      chk((gate_hi | gate_lo) == 0, "R10", "gates during fault", {gate_hi, gate_lo}, 0);
      rd(2'd1, v); chk(v == 32'd2, "R9", "status during fault", v, 2);
      wr(2'd1, 32'd1);
      rd(2'd1, v); chk(v == 32'd2, "R10", "enable write ignored in fault", v, 2);
      fault_in = 1'b1;
      clocks(3);
      rd(2'd1, v); chk(v == 32'd0, "R10", "enable stays clear after fault", v, 0);
      chk(amp_en == 0, "R10", "amp_en after fault cleared", amp_en, 0);
      ov = 0;
      repeat (100) begin @(negedge clk); if ((gate_hi | gate_lo) != 0) ov++; end
      chk(ov == 0, "R10", "gate clocks after fault cleared", ov, 0);
      wr(2'd1, 32'd1);
      chk(amp_en == 1, "R10", "re-enable after fault", amp_en, 1);

      // R9 fault, active high
      wr(2'd2, setup_word(0, 1, 0));
      clocks(3);
      rd(2'd1, v); chk(v == 32'd2, "R9", "high fault level detected", v, 2);
      fault_in = 1'b0;
      clocks(3);
      rd(2'd1, v); chk(v == 32'd0, "R9", "low input no fault at high polarity", v, 0);
      wr(2'd1, 32'd1);
      chk(amp_en == 1, "R9", "enable with high polarity", amp_en, 1);

      // R3 rate zero halts
      wr(2'd3, 32'd0);
      clocks(8);
      sc = 0;
      repeat (10000) begin @(negedge clk); if (smp_strobe) sc++; end
      chk(sc == 0, "R3", "strobes at rate 0", sc, 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule